// File: doc/BRIEF.md
# Ordered Primitive Work Splitter

This block feeds vertex work to four worker cores. A draw command arrives on a valid/ready stream with a draw identifier and a primitive count. The block cuts the draw into chunks of at most `threshold` primitives and offers each chunk to one core. A large draw is spread across several cores this way. A chunk is the smallest piece of work that a core can receive.

Each chunk carries a sequence tag that grows by one per issued chunk. A downstream stage uses the tag to put the results back into submission order. The target core is the one with the fewest outstanding chunks. A core's count rises when it accepts a chunk and falls when it pulses `coreDone`. Once a core accepts a chunk it works independently. The block only tracks how many chunks each core still holds.

All cores share one set of descriptor wires. The per-core `chunkValid` bit selects the receiving core, and the descriptor stays fixed until that core asserts its `chunkAccept` bit.

Top module: `prim_splitter`

## Requirements
- R1: After reset, `cmdReady` is 1, no `chunkValid` bit is set, and the first chunk issued carries sequence tag 0.
- R2: Each chunk covers a contiguous range of the draw. `chunkFirst` starts at 0 and grows by the previous chunk's count. `chunkCount` is the smaller of the remaining primitives and the threshold latched when the draw was accepted. A threshold of 0 is treated as 1.
- R3: `chunkLast` is 1 on the final chunk of a draw only. That chunk holds the remainder (count modulo threshold), or a full threshold when the count divides evenly.
- R4: A draw with a primitive count of 0 is consumed without issuing any chunk, and it does not advance the sequence tag.
- R5: `chunkSeq` grows by exactly one for each accepted chunk and wraps modulo 2^SEQ_W.
- R6: Each chunk goes to the core with the fewest outstanding chunks among cores below MAX_OUT. Ties go to the lowest core index.
- R7: A core's outstanding count rises by one when it accepts a chunk. It falls by one on a `coreDone` pulse. A `coreDone` pulse on a core holding no chunks has no effect.
- R8: While every core holds MAX_OUT chunks, `cmdReady` is 0. A draw already in progress withholds its next chunk until a `coreDone` frees room.
- R9: At most one `chunkValid` bit is set at a time. While an offer is not accepted, the valid bits and all descriptor fields stay stable.
- R10: Every chunk of a draw carries the draw identifier that was accepted with that draw.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| threshold | input | PRIM_W | Chunk size in primitives, latched when a draw is accepted (0 means 1) |
| cmdValid | input | 1 | Draw command valid |
| cmdReady | output | 1 | Draw command ready |
| cmdDrawId | input | ID_W | Draw identifier |
| cmdPrimCount | input | PRIM_W | Primitive count of the draw |
| chunkValid | output | NUM_CORES | One bit per core; set for the core being offered a chunk |
| chunkAccept | input | NUM_CORES | Per-core chunk acceptance |
| coreDone | input | NUM_CORES | Per-core pulse: one outstanding chunk finished |
| chunkDrawId | output | ID_W | Draw identifier of the offered chunk |
| chunkFirst | output | PRIM_W | Index of the first primitive, relative to the draw |
| chunkCount | output | PRIM_W | Primitives in the chunk |
| chunkLast | output | 1 | Final chunk of the draw |
| chunkSeq | output | SEQ_W | Global order tag |

## Verification
The splitter is driven with a range of draws:
- A count that leaves a remainder separates the remainder path from the full-chunk path.
- An exact multiple of the threshold checks that no empty trailing chunk appears.
- A draw smaller than the threshold must give a single chunk flagged last.
- A zero threshold must still make progress, one primitive per chunk.
- A zero-primitive draw must produce nothing and leave the tag sequence intact.

Core loads are made uneven between draws so that the least-loaded choice and the lowest-index tie break give different answers from plain rotation. A saturation run fills every core. It then frees one slot at a time, both before a draw is accepted and in the middle of a draw. This separates input back-pressure from chunk withholding. A done pulse on an idle core checks that its count does not wrap.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PICK,
    ST_OFFER
  } splitState_e;

  typedef struct packed {
    logic loadCmd;      // capture a new non-empty draw
    logic latchTarget;  // freeze the chosen core for the next offer
    logic advance;      // offered chunk taken: step counters
  } splitStrobe_t;

endpackage

// File: rtl/split_datapath.sv
module split_datapath
  import splitter_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int PRIM_W    = 16,
  parameter int ID_W      = 8,
  parameter int SEQ_W     = 4,
  parameter int MAX_OUT   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  splitStrobe_t         strobe,
  input  logic                 offering,
  input  logic [ID_W-1:0]      cmdDrawId,
  input  logic [PRIM_W-1:0]    cmdPrimCount,
  input  logic [PRIM_W-1:0]    threshold,
  input  logic [NUM_CORES-1:0] chunkAccept,
  input  logic [NUM_CORES-1:0] coreDone,
  output logic                 zeroCount,
  output logic                 allFull,
  output logic                 isLast,
  output logic                 targetAccept,
  output logic [NUM_CORES-1:0] chunkValid,
  output logic [ID_W-1:0]      chunkDrawId,
  output logic [PRIM_W-1:0]    chunkFirst,
  output logic [PRIM_W-1:0]    chunkCount,
  output logic [SEQ_W-1:0]     chunkSeq
);

  localparam int CORE_W = $clog2(NUM_CORES);
  localparam int OCNT_W = $clog2(MAX_OUT + 1);
  localparam logic [OCNT_W-1:0] MAX_CNT = OCNT_W'(MAX_OUT);

  logic [ID_W-1:0]   drawIdQ;
  logic [PRIM_W-1:0] remainQ, firstQ, thrQ;
  logic [SEQ_W-1:0]  seqQ;
  logic [CORE_W-1:0] targetQ, bestIdx;
  logic [OCNT_W-1:0] bestCnt;
  logic [NUM_CORES-1:0][OCNT_W-1:0] outCnt;
  logic [NUM_CORES-1:0] notFull;

  assign zeroCount    = (cmdPrimCount == '0);
  assign isLast       = (remainQ <= thrQ);
  assign chunkCount   = isLast ? remainQ : thrQ;
  assign chunkFirst   = firstQ;
  assign chunkDrawId  = drawIdQ;
  assign chunkSeq     = seqQ;
  assign targetAccept = chunkAccept[targetQ];
  assign allFull      = ~|notFull;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drawIdQ <= '0;
      remainQ <= '0;
      firstQ  <= '0;
      thrQ    <= PRIM_W'(1);
      seqQ    <= '0;
      targetQ <= '0;
    end else begin
      if (strobe.loadCmd) begin
        drawIdQ <= cmdDrawId;
        remainQ <= cmdPrimCount;
        firstQ  <= '0;
        thrQ    <= (threshold == '0) ? PRIM_W'(1) : threshold;
      end
      if (strobe.latchTarget) targetQ <= bestIdx;
      if (strobe.advance) begin
        remainQ <= remainQ - chunkCount;
        firstQ  <= firstQ + chunkCount;
        seqQ    <= seqQ + SEQ_W'(1);
      end
    end
  end

  // Per-core outstanding chunk counters
  for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_core
    logic [OCNT_W-1:0] cnt;
    logic inc, dec;
    assign inc = strobe.advance && (targetQ == CORE_W'(gi));
    assign dec = coreDone[gi] && (cnt != '0);
    always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (inc && !dec) cnt <= cnt + OCNT_W'(1);
      else if (dec && !inc) cnt <= cnt - OCNT_W'(1);
    end
    assign outCnt[gi]     = cnt;
    assign notFull[gi]    = (cnt < MAX_CNT);
    assign chunkValid[gi] = offering && (targetQ == CORE_W'(gi));
  end

  // Least-loaded search; full cores never beat the initial bound
  always_comb begin
    bestIdx = '0;
    bestCnt = MAX_CNT;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (outCnt[i] < bestCnt) begin
        bestCnt = outCnt[i];
        bestIdx = CORE_W'(i);
      end
    end
  end

endmodule

// File: rtl/split_control.sv
module split_control
  import splitter_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmdValid,
  input  logic         zeroCount,
  input  logic         allFull,
  input  logic         isLast,
  input  logic         targetAccept,
  output logic         cmdReady,
  output logic         offering,
  output splitStrobe_t strobe
);

  splitState_e state, stateNext;

  assign cmdReady           = (state == ST_IDLE) && !allFull;
  assign offering           = (state == ST_OFFER);
  assign strobe.loadCmd     = cmdReady && cmdValid && !zeroCount;
  assign strobe.latchTarget = (state == ST_PICK) && !allFull;
  assign strobe.advance     = offering && targetAccept;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (strobe.loadCmd) stateNext = ST_PICK;
      ST_PICK:  if (strobe.latchTarget) stateNext = ST_OFFER;
      ST_OFFER: if (strobe.advance) stateNext = isLast ? ST_IDLE : ST_PICK;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

endmodule

// File: rtl/prim_splitter.sv
module prim_splitter
  import splitter_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int PRIM_W    = 16,
  parameter int ID_W      = 8,
  parameter int SEQ_W     = 4,
  parameter int MAX_OUT   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PRIM_W-1:0]    threshold,
  input  logic                 cmdValid,
  output logic                 cmdReady,
  input  logic [ID_W-1:0]      cmdDrawId,
  input  logic [PRIM_W-1:0]    cmdPrimCount,
  output logic [NUM_CORES-1:0] chunkValid,
  input  logic [NUM_CORES-1:0] chunkAccept,
  input  logic [NUM_CORES-1:0] coreDone,
  output logic [ID_W-1:0]      chunkDrawId,
  output logic [PRIM_W-1:0]    chunkFirst,
  output logic [PRIM_W-1:0]    chunkCount,
  output logic                 chunkLast,
  output logic [SEQ_W-1:0]     chunkSeq
);

  splitStrobe_t strobe;
  logic zeroCount, allFull, isLast, targetAccept, offering;

  split_control u_ctl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .zeroCount(zeroCount),
    .allFull(allFull), .isLast(isLast), .targetAccept(targetAccept),
    .cmdReady(cmdReady), .offering(offering), .strobe(strobe)
  );

  split_datapath #(
    .NUM_CORES(NUM_CORES), .PRIM_W(PRIM_W), .ID_W(ID_W),
    .SEQ_W(SEQ_W), .MAX_OUT(MAX_OUT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .offering(offering),
    .cmdDrawId(cmdDrawId), .cmdPrimCount(cmdPrimCount), .threshold(threshold),
    .chunkAccept(chunkAccept), .coreDone(coreDone), .zeroCount(zeroCount),
    .allFull(allFull), .isLast(isLast), .targetAccept(targetAccept),
    .chunkValid(chunkValid), .chunkDrawId(chunkDrawId), .chunkFirst(chunkFirst),
    .chunkCount(chunkCount), .chunkSeq(chunkSeq)
  );

  assign chunkLast = isLast;

endmodule

// File: rtl/split_checker.sv
module split_checker #(
  parameter int NUM_CORES = 4,
  parameter int PRIM_W    = 16,
  parameter int ID_W      = 8,
  parameter int SEQ_W     = 4,
  parameter int MAX_OUT   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmdReady,
  input logic [NUM_CORES-1:0] chunkValid,
  input logic [NUM_CORES-1:0] chunkAccept,
  input logic [NUM_CORES-1:0] coreDone,
  input logic [ID_W-1:0]      chunkDrawId,
  input logic [PRIM_W-1:0]    chunkFirst,
  input logic [PRIM_W-1:0]    chunkCount,
  input logic                 chunkLast,
  input logic [SEQ_W-1:0]     chunkSeq
);

  localparam int OCNT_W = $clog2(MAX_OUT + 1) + 1;

  logic [SEQ_W-1:0] refSeq;
  logic [NUM_CORES-1:0] refFull;
  logic taken;

  assign taken = |(chunkValid & chunkAccept);

  always_ff @(posedge clk) begin
    if (!rst_n)     refSeq <= '0;
    else if (taken) refSeq <= refSeq + SEQ_W'(1);
  end

  // Outstanding load rebuilt from the port handshakes only
  for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_ref
    logic [OCNT_W-1:0] cnt;
    logic inc, dec;
    assign inc = chunkValid[gi] && chunkAccept[gi];
    assign dec = coreDone[gi] && (cnt != '0);
    always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (inc && !dec) cnt <= cnt + OCNT_W'(1);
      else if (dec && !inc) cnt <= cnt - OCNT_W'(1);
    end
    assign refFull[gi] = (cnt >= OCNT_W'(MAX_OUT));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      chunkValid[gi] |-> !refFull[gi]);  // R8
  end

  AST_SINGLE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chunkValid));  // R9

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|chunkValid && !taken) |=> ($stable(chunkValid) && $stable(chunkDrawId) &&
      $stable(chunkFirst) && $stable(chunkCount) && $stable(chunkLast) &&
      $stable(chunkSeq)));  // R9

  AST_SEQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    |chunkValid |-> (chunkSeq == refSeq));  // R5

  AST_NONEMPTY_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    |chunkValid |-> (chunkCount != '0));  // R2

  AST_FULL_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (&refFull) |-> !cmdReady);  // R8

endmodule

bind prim_splitter split_checker #(
  .NUM_CORES(NUM_CORES), .PRIM_W(PRIM_W), .ID_W(ID_W),
  .SEQ_W(SEQ_W), .MAX_OUT(MAX_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmdReady(cmdReady), .chunkValid(chunkValid),
  .chunkAccept(chunkAccept), .coreDone(coreDone), .chunkDrawId(chunkDrawId),
  .chunkFirst(chunkFirst), .chunkCount(chunkCount), .chunkLast(chunkLast),
  .chunkSeq(chunkSeq)
);

// File: tb/prim_splitter_test.sv
`timescale 1ns/1ps
module prim_splitter_test;

  localparam int NC = 4, PW = 16, IW = 8, SW = 4, MO = 3;
  localparam int NV = 6;
  // {drawId, primCount, threshold, retireMask}
  localparam int VEC [NV][4] = '{
    '{1, 10, 4, 15},
    '{2,  8, 4, 15},
    '{3,  3, 5,  0},
    '{4,  5, 0, 15},
    '{5,  0, 3,  0},
    '{6,  7, 7,  2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PW-1:0] threshold = '0;
  logic cmdValid = 1'b0, cmdReady;
  logic [IW-1:0] cmdDrawId = '0;
  logic [PW-1:0] cmdPrimCount = '0;
  logic [NC-1:0] chunkValid, chunkAccept = '0, coreDone = '0;
  logic [IW-1:0] chunkDrawId;
  logic [PW-1:0] chunkFirst, chunkCount;
  logic chunkLast;
  logic [SW-1:0] chunkSeq;

  int nChecks = 0, nFails = 0;
  int mOut [NC];
  int mSeq = 0;

  always #2.5 clk = ~clk;

  prim_splitter #(.NUM_CORES(NC), .PRIM_W(PW), .ID_W(IW), .SEQ_W(SW), .MAX_OUT(MO)) uut (
    .clk(clk), .rst_n(rst_n), .threshold(threshold), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdDrawId(cmdDrawId), .cmdPrimCount(cmdPrimCount),
    .chunkValid(chunkValid), .chunkAccept(chunkAccept), .coreDone(coreDone),
    .chunkDrawId(chunkDrawId), .chunkFirst(chunkFirst), .chunkCount(chunkCount),
    .chunkLast(chunkLast), .chunkSeq(chunkSeq)
  );

  task automatic check(string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int pickCore();
    int best = -1, bc = MO;
    for (int i = 0; i < NC; i++) if (mOut[i] < bc) begin bc = mOut[i]; best = i; end
    return best;
  endfunction

  task automatic sendDraw(int id, int prims, int thr);
    int guard = 0;
    @(negedge clk);
    cmdDrawId = IW'(id); cmdPrimCount = PW'(prims); threshold = PW'(thr); cmdValid = 1'b1;
    while (!cmdReady && guard < 100) begin @(negedge clk); guard++; end
    check("R8 draw accepted", int'(cmdReady), 1);
    @(posedge clk); #1 cmdValid = 1'b0;
  endtask

  task automatic expectChunk(int id, int first, int cnt, int last);
    int guard = 0, core = -1, exp;
    @(negedge clk);
    while (chunkValid == '0 && guard < 50) begin @(negedge clk); guard++; end
    check("R9 single offer", int'($onehot(chunkValid)), 1);
    for (int i = 0; i < NC; i++) if (chunkValid[i]) core = i;
    exp = pickCore();
    check("R6 target core", core, exp);
    check("R10 drawId", int'(chunkDrawId), id);
    check("R2 first", int'(chunkFirst), first);
    check("R2 count", int'(chunkCount), cnt);
    check("R3 last", int'(chunkLast), last);
    check("R5 seq", int'(chunkSeq), mSeq);
    if (core >= 0) begin
      chunkAccept = '0; chunkAccept[core] = 1'b1;
      @(posedge clk); #1 chunkAccept = '0;
      mOut[core]++;
    end
    mSeq = (mSeq + 1) % (1 << SW);
  endtask

  task automatic expectDraw(int id, int prims, int thr);
    int eff = (thr == 0) ? 1 : thr;
    int rem = prims, first = 0, c;
    while (rem > 0) begin
      c = (rem < eff) ? rem : eff;
      expectChunk(id, first, c, (rem <= eff) ? 1 : 0);
      rem -= c; first += c;
    end
  endtask

  task automatic retire(int mask);
    @(negedge clk);
    coreDone = NC'(mask);
    @(posedge clk); #1 coreDone = '0;
    for (int i = 0; i < NC; i++) if (mask[i] && mOut[i] > 0) mOut[i]--;
  endtask

  task automatic quiet(string what, int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      check(what, int'(chunkValid), 0);
    end
  endtask

  initial begin
    #1000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) mOut[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(cmdReady), 1);
    check("R1 no offer after reset", int'(chunkValid), 0);

    // Table walk: R2 R3 R4 R6 R10 (zero threshold and zero-count draws included)
    for (int v = 0; v < NV; v++) begin
      sendDraw(VEC[v][0], VEC[v][1], VEC[v][2]);
      expectDraw(VEC[v][0], VEC[v][1], VEC[v][2]);
      quiet("R4 no extra chunk", 3);
      if (VEC[v][3] != 0) retire(VEC[v][3]);
    end

    // Saturate every core (R8)
    for (int r = 0; r < MO; r++) retire(15);
    sendDraw(9, NC * MO, 1);
    expectDraw(9, NC * MO, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 ready low when all full", int'(cmdReady), 0);
    end
    retire(4);
    sendDraw(10, 2, 1);
    expectChunk(10, 0, 1, 0);
    quiet("R8 chunk withheld while full", 4);
    retire(1);
    expectChunk(10, 1, 1, 1);

    // Done pulse on an empty core is ignored (R7)
    for (int r = 0; r < MO; r++) retire(15);
    retire(1);
    retire(1);
    sendDraw(11, 1, 1);
    expectChunk(11, 0, 1, 1);
    retire(1);
    sendDraw(12, 3, 1);
    expectDraw(12, 3, 1);
    check("R7 model core0 load", mOut[0], 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule